// File: doc/BRIEF.md
# Sensor Register Command Scheduler

This block sits between a board's user controls and an SPI register-access controller for an accelerometer. Sixteen switches describe a register transaction. The low byte is the register address and the high byte is the byte to write. Two button pulses request a write or a read, and the block forwards these to the controller as single-register transactions. The switches are mirrored on sixteen LEDs. A further LED shows when the controller is busy.

The block also reads the three axis data registers in the background at a rate set by parameters. Every result is placed into its own byte of a 32-bit word that holds eight hex digits, ready for an external seven-segment scanner. User requests that arrive while the controller is occupied are remembered. Between polled registers, they take precedence over the polling sequence.

Top module: `sensor_cmd_sched`

## Requirements
- R1: `led` equals `sw` in every cycle, and `busy_led` equals `ctl_busy` in every cycle.
- R2: A `btn_wr` pulse produces exactly one controller transaction with `ctl_write`=1. It takes `ctl_addr` from `sw[7:0]` and `ctl_wdata` from `sw[15:8]`, both sampled in the cycle the transaction is issued. `ctl_addr` and `ctl_wdata` stay stable until `ctl_done`.
- R3: A `btn_rd` pulse produces one transaction with `ctl_write`=0 and `ctl_addr`=`sw[7:0]`. The `ctl_rdata` value present with `ctl_done` is stored in `disp_word[7:0]`. No other byte of `disp_word` changes. Outside a capture, `disp_word` holds its value.
- R4: `ctl_start` is a pulse that lasts one cycle and is raised only while `ctl_busy` is low. A request made while the controller is busy is held and issued after busy falls.
- R5: A second pulse of the same button while its request is still pending is merged into it. Only one transaction results.
- R6: When a write and a read are both pending, the write is issued first.
- R7: Every CLK_FREQUENCY/DISPLAY_RATE cycles a poll sequence is due. It reads address 0x08, then 0x09, then 0x0A, each with `ctl_write`=0. The first poll after reset is issued no earlier than that period and at most 3 cycles later.
- R8: Poll results go to `disp_word[15:8]` (0x08), `disp_word[23:16]` (0x09) and `disp_word[31:24]` (0x0A).
- R9: A pending user request is issued before a new poll sequence starts. If a sequence is already running, the axis read in flight completes, then the user request is issued, then the remaining axis reads follow.
- R10: A synchronous active-high `rst` clears `disp_word` to zero, drops both pending requests, restarts the poll timer and holds `ctl_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 16 | Switches: [7:0] register address, [15:8] write byte |
| btn_wr | input | 1 | Debounced write request pulse |
| btn_rd | input | 1 | Debounced read request pulse |
| ctl_busy | input | 1 | Controller is running a transaction |
| ctl_done | input | 1 | Controller finished a transaction (one cycle) |
| ctl_rdata | input | 8 | Byte returned by a read, valid with ctl_done |
| ctl_start | output | 1 | Begin a transaction (one cycle) |
| ctl_write | output | 1 | 1 = write, 0 = read |
| ctl_addr | output | 8 | Register address of the transaction |
| ctl_wdata | output | 8 | Byte to write |
| disp_word | output | 32 | Eight hex digits; digit 0 is bits [3:0] |
| led | output | 16 | Switch mirror |
| busy_led | output | 1 | Controller busy indicator |

## Verification
A user request and a poll becoming due can fall in the same cycle, and so can the end of one axis read and a pending button press. The bench provokes the first by keeping a user read in flight for longer than a poll period and pressing write during it. The expected order is the read, the write, then all three axis reads. It provokes the second by pressing read in the cycle an X-axis read is issued, and requires the user read to fall between the X and Y reads. Both cases are judged from the ordered log of transactions that the controller model records, and from the display bytes that result.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_AXES  = 3;
    localparam int N_SLOTS = N_AXES + 1;
    localparam logic [BYTE_W-1:0] AXIS_BASE = 8'h08;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_UWR  = 2'd1,
        K_URD  = 2'd2,
        K_POLL = 2'd3
    } kind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        kind_e             kind;
        logic              wr;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [1:0]        axis;
    } xact_t;

    function automatic logic [BYTE_W-1:0] axis_addr(input logic [1:0] idx);
        return AXIS_BASE + {6'd0, idx};
    endfunction

    function automatic logic [1:0] slot_of(input xact_t x);
        return (x.kind == K_POLL) ? x.axis + 2'd1 : 2'd0;
    endfunction

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/req_latch.sv
module req_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend | set) & ~clr;
    end

    p_keep_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
    import sched_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] sw,
    input  logic        wr_pend,
    input  logic        rd_pend,
    input  logic        tick,
    input  logic        busy,
    input  logic        done,
    output logic        take_wr,
    output logic        take_rd,
    output logic        start,
    output xact_t       cur,
    output logic        capture
);
    state_e     state;
    logic       poll_due;
    logic       seq_on;
    logic [1:0] axis_nxt;
    xact_t      pick;
    logic       go;

    always_comb begin
        pick       = '0;
        pick.kind  = K_NONE;
        pick.addr  = sw[7:0];
        pick.wdata = sw[15:8];
        if (state == S_IDLE && !busy) begin
            if (wr_pend) begin
                pick.kind = K_UWR;
                pick.wr   = 1'b1;
            end else if (rd_pend) begin
                pick.kind = K_URD;
            end else if (seq_on || poll_due) begin
                pick.kind  = K_POLL;
                pick.axis  = seq_on ? axis_nxt : 2'd0;
                pick.addr  = axis_addr(pick.axis);
                pick.wdata = '0;
            end
        end
    end

    assign go      = (pick.kind != K_NONE);
    assign take_wr = (pick.kind == K_UWR);
    assign take_rd = (pick.kind == K_URD);
    assign capture = (state == S_WAIT) && done && !cur.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            start    <= 1'b0;
            cur      <= '0;
            poll_due <= 1'b0;
            seq_on   <= 1'b0;
            axis_nxt <= '0;
        end else begin
            start <= 1'b0;
            if (go) begin
                start <= 1'b1;
                cur   <= pick;
                state <= S_WAIT;
                if (pick.kind == K_POLL) begin
                    if (!seq_on) poll_due <= 1'b0;
                    if (pick.axis == 2'(N_AXES - 1)) begin
                        seq_on <= 1'b0;
                    end else begin
                        seq_on   <= 1'b1;
                        axis_nxt <= pick.axis + 2'd1;
                    end
                end
            end else if (state == S_WAIT && done) begin
                state <= S_IDLE;
            end
            if (tick) poll_due <= 1'b1;
        end
    end

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
    p_start_free_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !done && !start) |=> $stable(cur.addr) && $stable(cur.wdata));
    p_poll_read_r7: assert property (@(posedge clk) disable iff (rst)
        (start && cur.kind == K_POLL) |-> (!cur.wr && cur.addr >= AXIS_BASE
                                           && cur.addr < AXIS_BASE + 8'(N_AXES)));
endmodule

// File: rtl/result_router.sv
module result_router
    import sched_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      capture,
    input  logic [1:0]                slot,
    input  logic [BYTE_W-1:0]         rdata,
    output logic [N_SLOTS*BYTE_W-1:0] word
);
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                word[g*BYTE_W +: BYTE_W] <= '0;
            else if (capture && slot == 2'(g))
                word[g*BYTE_W +: BYTE_W] <= rdata;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(word));
endmodule

// File: rtl/sensor_cmd_sched.sv
module sensor_cmd_sched
    import sched_pkg::*;
#(
    parameter int CLK_FREQUENCY = 100_000_000,
    parameter int DISPLAY_RATE  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] sw,
    input  logic        btn_wr,
    input  logic        btn_rd,
    input  logic        ctl_busy,
    input  logic        ctl_done,
    input  logic [7:0]  ctl_rdata,
    output logic        ctl_start,
    output logic        ctl_write,
    output logic [7:0]  ctl_addr,
    output logic [7:0]  ctl_wdata,
    output logic [31:0] disp_word,
    output logic [15:0] led,
    output logic        busy_led
);
    localparam int POLL_PERIOD = CLK_FREQUENCY / DISPLAY_RATE;

    logic       tick;
    logic [1:0] btn;
    logic [1:0] take;
    logic [1:0] pend;
    logic       capture;
    xact_t      cur;

    assign btn = {btn_rd, btn_wr};

    poll_timer #(.PERIOD(POLL_PERIOD)) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    for (genvar b = 0; b < 2; b++) begin : g_req
        req_latch u_latch (
            .clk (clk),
            .rst (rst),
            .set (btn[b]),
            .clr (take[b]),
            .pend(pend[b])
        );
    end

    issue_ctrl u_issue (
        .clk    (clk),
        .rst    (rst),
        .sw     (sw),
        .wr_pend(pend[0]),
        .rd_pend(pend[1]),
        .tick   (tick),
        .busy   (ctl_busy),
        .done   (ctl_done),
        .take_wr(take[0]),
        .take_rd(take[1]),
        .start  (ctl_start),
        .cur    (cur),
        .capture(capture)
    );

    result_router u_route (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .slot   (slot_of(cur)),
        .rdata  (ctl_rdata),
        .word   (disp_word)
    );

    assign ctl_write = cur.wr;
    assign ctl_addr  = cur.addr;
    assign ctl_wdata = cur.wdata;
    assign led       = sw;
    assign busy_led  = ctl_busy;

    p_led_mirror_r1: assert property (@(posedge clk) disable iff (rst)
        (led == sw) && (busy_led == ctl_busy));
endmodule

// File: tb/sensor_cmd_sched_tb.sv
module sensor_cmd_sched_tb;
    localparam int CLK_P = 10;
    localparam int FREQ  = 2000;
    localparam int RATE  = 2;
    localparam int P     = FREQ / RATE;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] sw;
    logic        btn_wr, btn_rd;
    logic        ctl_busy, ctl_done;
    logic [7:0]  ctl_rdata;
    logic        ctl_start, ctl_write;
    logic [7:0]  ctl_addr, ctl_wdata;
    logic [31:0] disp_word;
    logic [15:0] led;
    logic        busy_led;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sensor_cmd_sched #(.CLK_FREQUENCY(FREQ), .DISPLAY_RATE(RATE)) u_dut (
        .clk(clk), .rst(rst), .sw(sw), .btn_wr(btn_wr), .btn_rd(btn_rd),
        .ctl_busy(ctl_busy), .ctl_done(ctl_done), .ctl_rdata(ctl_rdata),
        .ctl_start(ctl_start), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .disp_word(disp_word), .led(led), .busy_led(busy_led)
    );

    // controller model with register file and transaction log
    logic [7:0] mem [256];
    int  lat = 4;
    int  mcnt;
    logic [7:0] m_addr, m_wd;
    logic       m_wr;
    logic       log_wr [256];
    logic [7:0] log_ad [256];
    logic [7:0] log_wd [256];
    int         log_t  [256];
    int         log_n = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(posedge clk) begin
        ctl_done <= 1'b0;
        if (rst) begin
            ctl_busy <= 1'b0;
        end else if (ctl_start && !ctl_busy) begin
            ctl_busy <= 1'b1;
            mcnt     <= lat - 1;
            m_addr   <= ctl_addr;
            m_wd     <= ctl_wdata;
            m_wr     <= ctl_write;
            if (log_n < 256) begin
                log_wr[log_n] <= ctl_write;
                log_ad[log_n] <= ctl_addr;
                log_wd[log_n] <= ctl_wdata;
                log_t[log_n]  <= cyc;
                log_n         <= log_n + 1;
            end
        end else if (ctl_busy) begin
            if (mcnt == 0) begin
                ctl_busy <= 1'b0;
                ctl_done <= 1'b1;
                if (m_wr) mem[m_addr] <= m_wd;
                else      ctl_rdata   <= mem[m_addr];
            end else begin
                mcnt <= mcnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input bit wr);
        if (wr) btn_wr = 1'b1; else btn_rd = 1'b1;
        @(negedge clk);
        btn_wr = 1'b0; btn_rd = 1'b0;
    endtask

    task automatic chk_entry(input int i, input bit wr, input logic [7:0] ad,
                             input logic [7:0] wd, input string tag);
        chk(log_wr[i] == wr && log_ad[i] == ad && (!wr || log_wd[i] == wd), tag,
            {15'd0, log_wr[i], log_ad[i], log_wd[i]}, {15'd0, wr, ad, wd});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n0, x, t_rel, base;
        logic [7:0] ad, dt;
        rst = 1'b1; sw = '0; btn_wr = 1'b0; btn_rd = 1'b0;
        cyc_n(5);
        // R10: reset state
        chk(disp_word == 0 && ctl_start == 0, "R10 reset state", disp_word, 0);
        rst = 1'b0;
        base = log_n;

        // R1: mirror sweep
        for (int i = 0; i < 16; i++) begin
            sw = 16'(i * 16'h1111) ^ 16'h0F0F;
            @(negedge clk);
            chk(led == sw && busy_led == ctl_busy, "R1 led mirror", {led, 15'd0, busy_led}, {sw, 15'd0, ctl_busy});
        end

        // R2 / R3 sweep of writes followed by reads
        for (int k = 0; k < 8; k++) begin
            ad = 8'h20 + 8'(k * 3);
            dt = 8'(k * 37 + 1);
            sw = {dt, ad};
            n0 = log_n;
            press(1);
            cyc_n(2);
            chk(busy_led == 1'b1 && ctl_busy == 1'b1, "R1 busy led", busy_led, 1);
            cyc_n(15);
            chk(log_n == n0 + 1, "R2 one write", log_n, n0 + 1);
            chk_entry(n0, 1, ad, dt, "R2 write fields");
            sw = {~dt, ad};
            press(0);
            cyc_n(17);
            chk_entry(n0 + 1, 0, ad, 0, "R3 read fields");
            chk(disp_word == {24'd0, dt}, "R3 read shown on digits 1:0", disp_word, {24'd0, dt});
        end
        // write Y axis register to a known value
        sw = {8'hC3, 8'h09};
        press(1);
        cyc_n(20);
        base = log_n;

        // R7 / R8: let two poll sequences run
        while (cyc < 2600) @(negedge clk);
        chk(log_n == base + 6, "R7 two poll sequences", log_n, base + 6);
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 3; a++)
                chk_entry(base + s*3 + a, 0, 8'h08 + 8'(a), 0, "R7 poll order");
        chk(log_t[base + 3] - log_t[base] == P, "R7 poll period", log_t[base + 3] - log_t[base], P);
        chk(disp_word[31:8] == {8'h50, 8'hC3, 8'h52}, "R8 axis digits", disp_word[31:8], {8'h50, 8'hC3, 8'h52});
        chk(disp_word[7:0] == 8'(7 * 37 + 1), "R3 user byte kept", disp_word[7:0], 8'(7 * 37 + 1));

        // sync just after a poll sequence
        while (!(ctl_start && ctl_addr == 8'h08)) @(negedge clk);
        cyc_n(40);

        // R4 / R5: requests while busy
        lat = 40;
        n0 = log_n;
        sw = {8'h00, 8'h30};
        press(0);
        cyc_n(6);
        sw = {8'h77, 8'h31};
        press(1);
        cyc_n(5);
        press(1);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (ctl_start && ctl_busy) chk(0, "R4 start while busy", 1, 0);
        end
        chk(log_n == n0 + 2, "R5 merged presses", log_n, n0 + 2);
        chk_entry(n0, 0, 8'h30, 0, "R4 first read");
        chk_entry(n0 + 1, 1, 8'h31, 8'h77, "R4 held write");
        chk(log_t[n0 + 1] - log_t[n0] >= 40, "R4 issued after busy", log_t[n0 + 1] - log_t[n0], 40);

        // R6: both pending
        n0 = log_n;
        sw = {8'h00, 8'h32};
        press(0);
        cyc_n(6);
        sw = {8'h99, 8'h34};
        press(0);
        press(1);
        cyc_n(150);
        chk(log_n == n0 + 3, "R6 count", log_n, n0 + 3);
        chk_entry(n0 + 1, 1, 8'h34, 8'h99, "R6 write first");
        chk_entry(n0 + 2, 0, 8'h34, 0, "R6 read second");
        chk(disp_word[7:0] == 8'h99, "R6 read returns written byte", disp_word[7:0], 8'h99);

        // R9a: user read lands between axis reads
        while (!(ctl_start && ctl_addr == 8'h08)) @(negedge clk);
        x = log_n;
        sw = {8'h00, 8'h21};
        press(0);
        cyc_n(250);
        chk_entry(x, 0, 8'h08, 0, "R9 axis X first");
        chk_entry(x + 1, 0, 8'h21, 0, "R9 user read after X");
        chk_entry(x + 2, 0, 8'h09, 0, "R9 axis Y after user");
        chk_entry(x + 3, 0, 8'h0A, 0, "R9 axis Z last");
        chk(disp_word[7:0] == mem[8'h21], "R9 user byte", disp_word[7:0], mem[8'h21]);

        // R9b: poll becomes due during a long user read, write pending
        lat = 1500;
        sw = {8'h00, 8'h22};
        x = log_n;
        press(0);
        while (!ctl_start) @(negedge clk);
        @(negedge clk);
        lat = 4;
        cyc_n(10);
        sw = {8'h5E, 8'h23};
        press(1);
        cyc_n(1600);
        chk_entry(x, 0, 8'h22, 0, "R9 long read");
        chk_entry(x + 1, 1, 8'h23, 8'h5E, "R9 write before poll");
        chk_entry(x + 2, 0, 8'h08, 0, "R9 poll X after user");
        chk_entry(x + 3, 0, 8'h09, 0, "R9 poll Y");
        chk_entry(x + 4, 0, 8'h0A, 0, "R9 poll Z");

        // R10: reset drops pending and display, restarts timer
        lat = 60;
        sw = {8'h00, 8'h40};
        press(0);
        cyc_n(5);
        press(1);
        rst = 1'b1;
        cyc_n(3);
        chk(disp_word == 0, "R10 display cleared", disp_word, 0);
        n0 = log_n;
        lat = 4;
        rst = 1'b0;
        t_rel = cyc;
        cyc_n(50);
        chk(log_n == n0, "R10 pending dropped", log_n, n0);
        while (!(ctl_start && ctl_addr == 8'h08)) @(negedge clk);
        cyc_n(2);
        chk(log_t[n0] - t_rel >= P && log_t[n0] - t_rel <= P + 3, "R7 first poll after reset",
            log_t[n0] - t_rel, P);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule